// File: doc/BRIEF.md
# Receive Auto-RTS Flow Controller

This block throttles a remote transmitter by driving the RTS modem line from the fill level of a receive FIFO. The host selects one of four trigger levels. When the FIFO occupancy reaches the selected level, RTS is driven high, which deasserts it and asks the sender to pause. RTS stays high until the FIFO has drained down to a lower reassert level. The band between the two levels gives hysteresis, so the line does not toggle while the FIFO holds near one level.

Every time RTS goes from low to high, the block can set an interrupt-identification flag. A read of the identification register clears this flag. The block also produces a receive-data-ready interrupt that uses the same trigger level. The FIFO storage, the serial receiver and the register decoding all sit outside this block and reach it through plain strobes and a count.

Top module: `rts_flow_ctrl`

## Requirements
- R1: After synchronous reset, `rts_pin` is 0 (asserted), `rts_int_id` is 0 and `rx_ready_int` is 0. The trigger select is code 0, which means a deassert level of 8.
- R2: A clock edge with `trig_wr`=1 loads `trig_sel`. The selected pair takes effect from the following edge. For DEPTH=64 the codes 0, 1, 2 and 3 give deassert levels 8, 16, 56 and 60. They give reassert levels 0, 8, 16 and 56.
- R3: With `afc_en`=1 and `rts_pin`=0, an edge with `rx_count` >= the deassert level sets `rts_pin` to 1.
- R4: With `rts_pin`=1, the pin stays 1 while `rx_count` is above the reassert level. It returns to 0 at the first edge with `rx_count` <= the reassert level.
- R5: An edge with `afc_en`=0 drives `rts_pin` to 0 and sets no RTS interrupt.
- R6: A 0-to-1 change of `rts_pin` with `rts_ie`=1 sets `rts_int_id` at the same edge.
- R7: A 0-to-1 change of `rts_pin` with `rts_ie`=0 leaves `rts_int_id` unchanged.
- R8: An edge with `iir_rd`=1 clears `rts_int_id`. If a new set happens at the same edge, the set wins.
- R9: `rx_ready_int` equals (`rx_count` >= deassert level) as sampled at the previous edge. This holds whatever the value of `afc_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W (7) | Receive FIFO occupancy |
| trig_sel | input | 2 | Trigger level code to load |
| trig_wr | input | 1 | Load strobe for trig_sel |
| afc_en | input | 1 | Automatic RTS enable |
| rts_ie | input | 1 | RTS interrupt enable |
| iir_rd | input | 1 | Identification register read strobe |
| rts_pin | output | 1 | RTS line level, 1 = deasserted |
| rts_int_id | output | 1 | RTS interrupt identification flag |
| rx_ready_int | output | 1 | Receive-data-ready interrupt |

## Verification
The bench walks the FIFO count across both edges of each hysteresis band. It holds the count one entry above the reassert level, where a design that compared against the deassert level again would release RTS too early. It checks the default level after reset, where a wrong reset code would move the stop point away from 8. It then switches to interrupt enable off, where a leaky design would still raise the flag. It also lines up a clearing read in the same cycle as a new rising edge, where the wrong priority would lose the interrupt. Finally, it checks that disabling flow control pulls RTS low at once while the data-ready interrupt still follows the count.

// File: rtl/rts_flow_pkg.sv
package rts_flow_pkg;

    typedef enum logic [1:0] {
        TRIG_LVL0 = 2'd0,
        TRIG_LVL1 = 2'd1,
        TRIG_LVL2 = 2'd2,
        TRIG_LVL3 = 2'd3
    } trig_sel_e;

    localparam int unsigned NUM_LVL = 4;

    // Occupancy at which RTS is released (driven high) for a given code.
    function automatic int unsigned deassert_lvl(int unsigned depth, int unsigned idx);
        case (idx)
            0:       return depth / 8;
            1:       return depth / 4;
            2:       return depth - depth / 8;
            default: return depth - depth / 16;
        endcase
    endfunction

    // Occupancy at or below which RTS is driven low again.
    function automatic int unsigned reassert_lvl(int unsigned depth, int unsigned idx);
        if (idx == 0) return 0;
        return deassert_lvl(depth, idx - 1);
    endfunction

    typedef struct packed {
        logic off;
        logic irq;
        logic rdy;
    } rts_out_t;

endpackage

// File: rtl/rts_trig_sel.sv
module rts_trig_sel
    import rts_flow_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [1:0]       sel_in,
    output logic [CNT_W-1:0] hi,
    output logic [CNT_W-1:0] lo
);

    trig_sel_e        trig_q;
    logic [CNT_W-1:0] hi_tab [NUM_LVL];
    logic [CNT_W-1:0] lo_tab [NUM_LVL];

    for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_lvl
        assign hi_tab[gi] = CNT_W'(deassert_lvl(DEPTH, int'(gi)));
        assign lo_tab[gi] = CNT_W'(reassert_lvl(DEPTH, int'(gi)));
    end

    always_ff @(posedge clk) begin
        if (rst)     trig_q <= TRIG_LVL0;
        else if (wr) trig_q <= trig_sel_e'(sel_in);
    end

    assign hi = hi_tab[trig_q];
    assign lo = lo_tab[trig_q];

endmodule

// File: rtl/rts_hyst.sv
module rts_hyst #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    output logic             off,
    output logic             rise
);

    logic off_nxt;

    always_comb begin
        off_nxt = off;
        if (!en)                    off_nxt = 1'b0;
        else if (!off && cnt >= hi) off_nxt = 1'b1;
        else if (off && cnt <= lo)  off_nxt = 1'b0;
    end

    assign rise = !off && off_nxt;

    always_ff @(posedge clk) begin
        if (rst) off <= 1'b0;
        else     off <= off_nxt;
    end

endmodule

// File: rtl/rts_irq_flag.sv
module rts_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/rts_flow_ctrl.sv
module rts_flow_ctrl
    import rts_flow_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] rx_count,
    input  logic [1:0]       trig_sel,
    input  logic             trig_wr,
    input  logic             afc_en,
    input  logic             rts_ie,
    input  logic             iir_rd,
    output logic             rts_pin,
    output logic             rts_int_id,
    output logic             rx_ready_int
);

    logic [CNT_W-1:0] thr_hi;
    logic [CNT_W-1:0] thr_lo;
    logic             rts_rise;
    rts_out_t         st;

    rts_trig_sel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) i_trig (
        .clk    (clk),
        .rst    (rst),
        .wr     (trig_wr),
        .sel_in (trig_sel),
        .hi     (thr_hi),
        .lo     (thr_lo)
    );

    rts_hyst #(.CNT_W(CNT_W)) i_hyst (
        .clk  (clk),
        .rst  (rst),
        .en   (afc_en),
        .cnt  (rx_count),
        .hi   (thr_hi),
        .lo   (thr_lo),
        .off  (st.off),
        .rise (rts_rise)
    );

    rts_irq_flag i_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (rts_rise && rts_ie),
        .clr  (iir_rd),
        .flag (st.irq)
    );

    always_ff @(posedge clk) begin
        if (rst) st.rdy <= 1'b0;
        else     st.rdy <= (rx_count >= thr_hi);
    end

    assign rts_pin      = st.off;
    assign rts_int_id   = st.irq;
    assign rx_ready_int = st.rdy;

endmodule

// File: rtl/rts_flow_chk.sv
module rts_flow_chk #(
    parameter int unsigned CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] rx_count,
    input logic             afc_en,
    input logic             rts_ie,
    input logic             iir_rd,
    input logic             rts_pin,
    input logic             rts_int_id,
    input logic             rx_ready_int,
    input logic [CNT_W-1:0] thr_hi,
    input logic [CNT_W-1:0] thr_lo
);

    assert_deassert_at_level_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_pin) |-> ($past(rx_count) >= $past(thr_hi)));

    assert_reassert_at_level_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(rts_pin) |-> (!$past(afc_en) || ($past(rx_count) <= $past(thr_lo))));

    assert_low_when_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        !afc_en |=> !rts_pin);

    assert_flag_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        ($rose(rts_pin) && $past(rts_ie)) |-> rts_int_id);

    assert_flag_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(rts_int_id) |-> ($rose(rts_pin) && $past(rts_ie)));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(iir_rd) && !$rose(rts_pin)) |-> !rts_int_id);

    assert_ready_level_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rx_ready_int == ($past(rx_count) >= $past(thr_hi))));

endmodule

bind rts_flow_ctrl rts_flow_chk #(.CNT_W(CNT_W)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .rx_count     (rx_count),
    .afc_en       (afc_en),
    .rts_ie       (rts_ie),
    .iir_rd       (iir_rd),
    .rts_pin      (rts_pin),
    .rts_int_id   (rts_int_id),
    .rx_ready_int (rx_ready_int),
    .thr_hi       (thr_hi),
    .thr_lo       (thr_lo)
);

// File: tb/test_rts_flow_ctrl.sv
`timescale 1ns/100ps
module test_rts_flow_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] rx_count = '0;
    logic [1:0] trig_sel = '0;
    logic       trig_wr = 1'b0;
    logic       afc_en = 1'b0;
    logic       rts_ie = 1'b0;
    logic       iir_rd = 1'b0;
    logic       rts_pin, rts_int_id, rx_ready_int;

    rts_flow_ctrl i_rts_flow_ctrl (
        .clk(clk), .rst(rst), .rx_count(rx_count), .trig_sel(trig_sel),
        .trig_wr(trig_wr), .afc_en(afc_en), .rts_ie(rts_ie), .iir_rd(iir_rd),
        .rts_pin(rts_pin), .rts_int_id(rts_int_id), .rx_ready_int(rx_ready_int)
    );

    always #2 clk = ~clk;

    typedef struct {
        int    due;
        logic  pin;
        logic  flg;
        logic  rdy;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    // reference state, built from the requirements
    int   m_trig = 0;
    logic m_off = 1'b0;
    logic m_flag = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int hi_of(int code);
        case (code)
            0: return 8;
            1: return 16;
            2: return 56;
            default: return 60;
        endcase
    endfunction

    function automatic int lo_of(int code);
        case (code)
            0: return 0;
            1: return 8;
            2: return 16;
            default: return 56;
        endcase
    endfunction

    task automatic step(input int cnt, input int sel, input logic wr, input logic afc,
                        input logic ie, input logic rd, input string tag);
        exp_t e;
        logic off_n, set;
        int   hi, lo;
        @(posedge clk); #1;
        rx_count = 7'(cnt); trig_sel = 2'(sel); trig_wr = wr;
        afc_en = afc; rts_ie = ie; iir_rd = rd;
        hi = hi_of(m_trig);
        lo = lo_of(m_trig);
        off_n = m_off;
        if (!afc)                 off_n = 1'b0;
        else if (!m_off && cnt >= hi) off_n = 1'b1;
        else if (m_off && cnt <= lo)  off_n = 1'b0;
        set = afc && ie && !m_off && off_n;
        if (set)     m_flag = 1'b1;
        else if (rd) m_flag = 1'b0;
        m_off = off_n;
        if (wr) m_trig = sel;
        e.due = cyc + 1; e.pin = m_off; e.flg = m_flag; e.rdy = (cnt >= hi); e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares design outputs against queued expectations
    initial begin
        forever begin
            @(posedge clk); #3;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if ({rts_pin, rts_int_id, rx_ready_int} !== {e.pin, e.flg, e.rdy}) begin
                    bad++;
                    $display("FAIL %s: pin/flag/rdy actual=%b%b%b expected=%b%b%b",
                             e.tag, rts_pin, rts_int_id, rx_ready_int, e.pin, e.flg, e.rdy);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        total++;
        if ({rts_pin, rts_int_id, rx_ready_int} !== 3'b000) begin
            bad++;
            $display("FAIL R1 reset: actual=%b%b%b expected=000", rts_pin, rts_int_id, rx_ready_int);
        end
        // R1: default level 8, R3 deassert, R6 flag
        for (int c = 4; c <= 9; c++) step(c, 0, 0, 1, 1, 0, "R1_R3_R6 ramp to level 8");
        // R4: only reassert at 0
        for (int c = 7; c >= 0; c--) step(c, 0, 0, 1, 1, 0, "R4 drain to 0");
        // R8 clear by read
        step(0, 0, 0, 1, 1, 1, "R8 read clears");
        step(0, 0, 0, 1, 1, 0, "R8 stays clear");
        // R2: code 2 -> 56/16
        step(10, 2, 1, 1, 1, 0, "R2 load code 2");
        for (int c = 50; c <= 57; c++) step(c, 0, 0, 1, 1, 0, "R2_R9 level 56");
        step(17, 0, 0, 1, 1, 1, "R4 hold above 16");
        step(16, 0, 0, 1, 1, 0, "R4 reassert at 16");
        // code 3 -> 60/56
        step(20, 3, 1, 1, 1, 0, "R2 load code 3");
        step(59, 0, 0, 1, 1, 0, "R2 below 60");
        step(60, 0, 0, 1, 1, 1, "R8 set wins over read");
        step(57, 0, 0, 1, 1, 0, "R4 hold above 56");
        step(56, 0, 0, 1, 1, 0, "R4 reassert at 56");
        // R7: interrupt disabled, code 1 -> 16/8
        step(0, 1, 1, 1, 0, 1, "R7 load code 1");
        for (int c = 14; c <= 17; c++) step(c, 0, 0, 1, 0, 0, "R7 rise without enable");
        // R5: disable flow control with full FIFO
        step(64, 0, 0, 0, 1, 0, "R5_R9 disabled full");
        step(64, 0, 0, 0, 1, 0, "R5 stays low");
        step(3, 0, 0, 1, 1, 0, "R5 re-enable low count");
        step(16, 0, 0, 1, 1, 0, "R6 rise with enable");
        step(8, 0, 0, 1, 1, 0, "R4 reassert at 8");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule